// File: doc/BRIEF.md
# Phase-Shifted Full-Bridge Leg Sequencer

This block produces the four raw switch commands of a full bridge. One leg (outputs A and B) is a pair of complementary square waves. Each output of that pair changes state once per oscillator period, so it runs at half the oscillator rate with 50% duty. The second leg (outputs C and D) has the same complementary form, but C is delayed from A by a programmable number of clock cycles. Power transfer is therefore set by the phase offset between the legs and not by pulse width. The outputs carry no dead time; a downstream stage inserts it.

The oscillator is a counter that runs from zero to a programmable last value and then restarts. Each restart is sent out as a one-cycle pulse on `sync_out`. A rising level on `sync_in` overrides the counter. It starts a new period at once and holds the counter at zero for as long as it stays high. During that time no pulse goes out. A phase word sets the cycle within the period at which the shifted leg changes state. The word is captured only when a period starts. `force_low` blanks all four commands immediately and freezes both legs in place.

Top module: `psfb_pwm_core`

## Requirements
- R1: While reset is asserted, out_a=0, out_b=1, out_c=1, out_d=0 and sync_out=0.
- R2: With period_last=L and no sync or force, out_a and out_b are complementary and each changes once every L+1 cycles. sync_out is high for exactly the one cycle in which the new out_a/out_b value first appears.
- R3: With phase word P and M=min(P,L), out_c rises exactly M+1 cycles after out_a rises. out_d is always the complement of out_c while force_low is low.
- R4: A phase word of L or more gives the maximum shift: out_c rises L+1 cycles after out_a rises, which is the cycle in which out_a falls.
- R5: A phase word of 0 still leaves a residual lag of one cycle between the rise of out_a and the rise of out_c.
- R6: A phase word that changes inside a period has no effect until the next period starts. The current period keeps its old lag.
- R7: A cycle in which sync_in is sampled high after being low starts a new period. out_a/out_b change at that edge and the counter restarts from zero. The counter is held at zero while sync_in stays high. The next change of out_a comes L+1 cycles after the last cycle in which sync_in was sampled high.
- R8: sync_out stays low in every cycle that follows a cycle with sync_in high.
- R9: force_low drives all four outputs low in the same cycle and freezes both legs. On release, out_a and out_c return to the values they had just before force_low was applied.
- R10: If a period ends before the shifted leg has made its change for that period (for example when cut short by sync_in), out_c/out_d change at the period start together with out_a/out_b. The shifted leg therefore changes exactly once per period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_last | input | CNT_W | Last counter value of a period (period = period_last+1 cycles) |
| phase_cmd | input | CNT_W | Phase word: lag of the shifted leg, in cycles minus one |
| sync_in | input | 1 | External level sync; a rising level restarts the period and high holds the counter |
| force_low | input | 1 | Blanks all four commands and freezes the legs |
| out_a | output | 1 | Reference leg, high-side command |
| out_b | output | 1 | Reference leg, low-side command |
| out_c | output | 1 | Shifted leg, high-side command |
| out_d | output | 1 | Shifted leg, low-side command |
| sync_out | output | 1 | One-cycle pulse at each internal period restart |

## Verification
A table of period/phase pairs covers short and long periods and phase words of zero, mid-range, exactly the last count and far above it. Measuring both the out_a-to-out_c lag and the out_a high time separates an error in the phase compare from an error in the period counter, and separates the clamp from the residual one-cycle lag. Directed runs change the phase word inside a period, which exposes a design that does not wait for the period start. They also pulse sync_in before the shifted leg has changed, which tests the counter hold, the missing sync_out pulse and the catch-up change of the shifted leg together. A force window that spans several periods shows whether the leg state really freezes rather than being masked only at the outputs.

// File: rtl/psfb_pkg.sv
package psfb_pkg;
  localparam int NUM_LEGS = 2;
  localparam int LEG_REF  = 0;
  localparam int LEG_SHFT = 1;

  typedef struct packed {
    logic hi;
    logic lo;
  } leg_drv_t;
endpackage

// File: rtl/psfb_period_timer.sv
module psfb_period_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period_last,
  input  logic             sync_in,
  output logic [CNT_W-1:0] cnt_o,
  output logic             start_o,
  output logic             wrap_o,
  output logic             run_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sync_prev_q;
  logic             sync_rise, wrap, cnt_clr;

  always_comb begin
    sync_rise = sync_in & ~sync_prev_q;
    wrap      = ~sync_in & (cnt_q >= period_last);
    cnt_clr   = sync_in | wrap;
    cnt_d     = cnt_clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q       <= '0;
      sync_prev_q <= 1'b0;
    end else begin
      cnt_q       <= cnt_d;
      sync_prev_q <= sync_in;
    end
  end

  assign cnt_o   = cnt_q;
  assign start_o = sync_rise | wrap;
  assign wrap_o  = wrap;
  assign run_o   = ~sync_in;
endmodule

// File: rtl/psfb_phase_match.sv
module psfb_phase_match #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] period_last,
  input  logic [CNT_W-1:0] phase_cmd,
  output logic             hit_o
);
  logic [CNT_W-1:0] ph_q, ph_d;
  logic             ph_en;
  logic [CNT_W-1:0] match;

  always_comb begin
    ph_en = start;
    ph_d  = phase_cmd;
    match = (ph_q >= period_last) ? period_last : ph_q;
    hit_o = run & (cnt == match);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ph_q <= '0;
    else if (ph_en) ph_q <= ph_d;
  end
endmodule

// File: rtl/psfb_leg_toggle.sv
module psfb_leg_toggle
  import psfb_pkg::*;
#(
  parameter logic RST_VAL = 1'b0
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tgl_req,
  input  logic     force_low,
  output logic     state_o,
  output leg_drv_t drv_o
);
  logic state_q, state_d, state_en;

  always_comb begin
    state_en = tgl_req & ~force_low;
    state_d  = ~state_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= RST_VAL;
    else if (state_en) state_q <= state_d;
  end

  assign state_o  = state_q;
  assign drv_o.hi = state_q & ~force_low;
  assign drv_o.lo = ~state_q & ~force_low;
endmodule

// File: rtl/psfb_pwm_core.sv
module psfb_pwm_core
  import psfb_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period_last,
  input  logic [CNT_W-1:0] phase_cmd,
  input  logic             sync_in,
  input  logic             force_low,
  output logic             out_a,
  output logic             out_b,
  output logic             out_c,
  output logic             out_d,
  output logic             sync_out
);
  logic [CNT_W-1:0]    cnt;
  logic                start, wrap, run, hit;
  logic                owe;
  logic                sync_out_q;
  logic [NUM_LEGS-1:0] tgl_req;
  logic [NUM_LEGS-1:0] leg_state;
  leg_drv_t            drv [NUM_LEGS];

  psfb_period_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .period_last(period_last), .sync_in(sync_in),
    .cnt_o(cnt), .start_o(start), .wrap_o(wrap), .run_o(run)
  );

  psfb_phase_match #(.CNT_W(CNT_W)) u_match (
    .clk(clk), .rst_n(rst_n), .start(start), .run(run), .cnt(cnt),
    .period_last(period_last), .phase_cmd(phase_cmd), .hit_o(hit)
  );

  // The shifted leg still owes its change for this period while the two
  // leg states differ; the phase relation lives in the states themselves.
  always_comb begin
    owe               = leg_state[LEG_REF] ^ leg_state[LEG_SHFT];
    tgl_req[LEG_REF]  = start;
    tgl_req[LEG_SHFT] = (hit | start) & owe;
  end

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    localparam logic RST_V = (g == LEG_SHFT) ? 1'b1 : 1'b0;
    psfb_leg_toggle #(.RST_VAL(RST_V)) u_leg (
      .clk(clk), .rst_n(rst_n), .tgl_req(tgl_req[g]), .force_low(force_low),
      .state_o(leg_state[g]), .drv_o(drv[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_out_q <= 1'b0;
    else        sync_out_q <= wrap;
  end

  assign out_a    = drv[LEG_REF].hi;
  assign out_b    = drv[LEG_REF].lo;
  assign out_c    = drv[LEG_SHFT].hi;
  assign out_d    = drv[LEG_SHFT].lo;
  assign sync_out = sync_out_q;
endmodule

// File: rtl/psfb_pwm_core_chk.sv
module psfb_pwm_core_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sync_in,
  input logic             force_low,
  input logic             out_a,
  input logic             out_b,
  input logic             out_c,
  input logic             out_d,
  input logic             sync_out,
  input logic [1:0]       leg_state,
  input logic [CNT_W-1:0] cnt
);
  assert_force_blanks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    force_low |-> !(out_a | out_b | out_c | out_d));

  assert_force_freezes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(force_low) |-> $stable(leg_state));

  assert_pulse_marks_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_out && !$past(force_low)) |-> (leg_state[0] != $past(leg_state[0])));

  assert_sync_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_in) |=> (cnt == '0));

  assert_no_pulse_in_sync_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sync_in) |-> !sync_out);
endmodule

bind psfb_pwm_core psfb_pwm_core_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .force_low(force_low),
  .out_a(out_a), .out_b(out_b), .out_c(out_c), .out_d(out_d),
  .sync_out(sync_out), .leg_state(leg_state), .cnt(cnt)
);

// File: tb/psfb_pwm_core_tb.sv
module psfb_pwm_core_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] period_last, phase_cmd;
  logic         sync_in, force_low;
  logic         out_a, out_b, out_c, out_d, sync_out;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  psfb_pwm_core #(.CNT_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .period_last(period_last), .phase_cmd(phase_cmd),
    .sync_in(sync_in), .force_low(force_low), .out_a(out_a), .out_b(out_b),
    .out_c(out_c), .out_d(out_d), .sync_out(sync_out)
  );

  // {period_last, phase_cmd, expected rise-to-rise lag}
  localparam logic [23:0] VEC [0:9] = '{
    {8'd9,  8'd0,   8'd1},  {8'd9,  8'd4,   8'd5},  {8'd9,  8'd9,   8'd10},
    {8'd9,  8'd200, 8'd10}, {8'd19, 8'd7,   8'd8},  {8'd19, 8'd19,  8'd20},
    {8'd4,  8'd2,   8'd3},  {8'd99, 8'd0,   8'd1},  {8'd99, 8'd50,  8'd51},
    {8'd3,  8'd3,   8'd4}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_a_rise();
    bit p = out_a;
    for (int g = 0; g < 1000; g++) begin
      @(negedge clk);
      if (!p && out_a) break;
      p = out_a;
    end
  endtask

  task automatic measure(input int lim, output int a_n, output int c_n);
    a_n = 0;
    c_n = 0;
    for (int k = 1; k <= lim; k++) begin
      @(negedge clk);
      if (out_c && c_n == 0) c_n = k;
      if (!out_a && a_n == 0) a_n = k;
      if (a_n != 0 && c_n != 0) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int an, cn, a0, c0, n;
    bit ok;
    rst_n = 1'b0; sync_in = 1'b0; force_low = 1'b0;
    period_last = 8'd9; phase_cmd = 8'd0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(out_a == 0 && out_b == 1 && out_c == 1 && out_d == 0 && sync_out == 0,
        "R1", {out_a, out_b, out_c, out_d, sync_out}, 5'b01100);
    rst_n = 1'b1;

    // Table walk: R2 period, R3/R4/R5 lag
    for (int i = 0; i < 10; i++) begin
      int term, lag;
      term = int'(VEC[i][23:16]);
      lag  = int'(VEC[i][7:0]);
      period_last = VEC[i][23:16];
      phase_cmd   = VEC[i][15:8];
      repeat (6 * (term + 1) + 4) @(negedge clk);
      wait_a_rise();
      chk(sync_out == 1'b1, "R2", sync_out, 1);
      chk(out_b == !out_a && out_d == !out_c, "R3", {out_b, out_d}, {!out_a, !out_c});
      measure(2 * (term + 1) + 2, an, cn);
      chk(an == term + 1, "R2", an, term + 1);
      if (lag == 1)             chk(cn == lag, "R5", cn, lag);
      else if (lag == term + 1) chk(cn == lag, "R4", cn, lag);
      else                      chk(cn == lag, "R3", cn, lag);
    end

    // R6: phase change inside a period waits for the next period
    period_last = 8'd9; phase_cmd = 8'd2;
    repeat (60) @(negedge clk);
    wait_a_rise();
    phase_cmd = 8'd6;
    measure(25, an, cn);
    chk(cn == 3, "R6", cn, 3);
    wait_a_rise();
    measure(25, an, cn);
    chk(cn == 7, "R6", cn, 7);

    // R7/R8/R10: sync pulse before the shifted leg has changed
    phase_cmd = 8'd4;
    repeat (60) @(negedge clk);
    wait_a_rise();
    repeat (2) @(negedge clk);
    sync_in = 1'b1;
    @(negedge clk);
    chk(out_a == 0, "R7", out_a, 0);
    chk(out_c == 1 && out_d == 0, "R10", out_c, 1);
    chk(sync_out == 0, "R8", sync_out, 0);
    ok = 1'b1;
    repeat (2) begin
      @(negedge clk);
      if (sync_out != 0 || out_a != 0) ok = 1'b0;
    end
    chk(ok, "R8", {sync_out, out_a}, 0);
    sync_in = 1'b0;
    n = 0;
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      if (out_a) begin n = k; break; end
    end
    chk(n == 10, "R7", n, 10);
    chk(sync_out == 1, "R2", sync_out, 1);

    // R9: force blanks and freezes
    repeat (13) @(negedge clk);
    a0 = out_a; c0 = out_c;
    force_low = 1'b1;
    #1;
    chk(!(out_a | out_b | out_c | out_d), "R9", {out_a, out_b, out_c, out_d}, 0);
    ok = 1'b1;
    repeat (23) begin
      @(negedge clk);
      if (out_a | out_b | out_c | out_d) ok = 1'b0;
    end
    chk(ok, "R9", {out_a, out_b, out_c, out_d}, 0);
    force_low = 1'b0;
    #1;
    chk(out_a == a0 && out_c == c0, "R9", {out_a, out_c}, {a0[0], c0[0]});
    chk(out_b == !out_a && out_d == !out_c, "R9", {out_b, out_d}, {!out_a, !out_c});

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule